// File: doc/BRIEF.md
# Character LCD Command Interpreter

This block is the host-side front end of a dot-matrix character display controller. The host performs byte-wide bus accesses. Each access is qualified by a register-select line (`rs`) and a read/write line (`bus_rd`).

With `rs` low, a write is a command. The block classifies the command byte by a prefix of variable length. It then updates one group of control fields or the address counter, and starts a busy interval whose length depends on the command. With `rs` low, a read returns status: the busy flag and the address counter. With `rs` high, an access is a display-RAM data transfer. The RAMs sit outside this block, so here such an access only steps the address counter.

Busy timing comes from a two-state machine in `lcd_busy_fsm`:
- `ST_IDLE` moves to `ST_EXEC` on transition *accept*, when a timed command is taken.
- `ST_EXEC` stays in place on transition *count* while its down-counter is above zero.
- `ST_EXEC` returns to `ST_IDLE` on transition *done* when the counter reaches zero.

Busy is high exactly while the machine is in `ST_EXEC`. Command classification takes place in `lcd_cmd_classify`. The address counter is held in `lcd_addr_counter`.

The clear and oscillator-start commands also emit a one-cycle request pulse. Downstream display logic uses these pulses.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: During and after reset, every control output is 0, the address counter is 0, busy is 0 and both request pulses are 0.
- R2: `rdata` equals {busy, address counter} while `rs`=0, and equals 0x00 while `rs`=1. A status read never changes state.
- R3: Command 0x01 sets the address counter to 0 and pulses `clear_req` for one cycle after the accepting edge. Busy is then high for exactly CLR_CYCLES (default 310) cycles.
- R4: Command 0x02 sets the address counter to 0 and holds busy for CMD_CYCLES (default 10) cycles.
- R5: Command 0x03 pulses `osc_req` for one cycle and leaves busy low. Byte 0x00 and the bytes 0xC4–0xDF change nothing and leave busy low.
- R6: Each of four 3-bit commands copies byte bits 2..0 into its field. 000001xx loads `inc_dir`=bit 1 and `clk_div`=bit 0. 00001xxx loads `cur_flags`. 00010xxx loads `disp_flags`. 00011xxx loads `pwr_flags`.
- R7: 001xxxxx loads `line_cnt`=bits 4..3 and `dbl_line`=bits 2..0. 010xxxxx loads `start_line[2]`=bit 4 and `contrast`=bits 3..0. 011xxxxx loads `start_line[1:0]`=bits 4..3 and `start_row`=bits 2..0. Each of these commands leaves the other start-line bits unchanged.
- R8: 100xxxxx loads `ann_en`=bit 4 and `ann_addr`=bits 3..0.
- R9: 101xxxxx loads the address counter with {00, bits 4..0}.
- R10: 110000xx replaces address counter bits 6..5 with byte bits 1..0. 111xxxxx replaces address counter bits 4..0 with byte bits 4..0. Each keeps the other part of the counter.
- R11: Every command in R4, R6–R10 raises busy on the cycle after the accepting edge and holds it for CMD_CYCLES cycles.
- R12: A command write that arrives while busy is high has no effect on any output, including busy.
- R13: A data access (`rs`=1, read or write) steps the address counter by +1 when `inc_dir`=1 and by −1 when `inc_dir`=0. The count wraps modulo 128, and the access never raises busy, even while busy is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | One-cycle access strobe |
| rs | input | 1 | 0 = command/status, 1 = data |
| bus_rd | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Status or data read byte |
| busy | output | 1 | Command still executing |
| addr_cnt | output | 7 | Address counter |
| inc_dir | output | 1 | Address step direction (1 = up) |
| clk_div | output | 1 | System clock division select |
| cur_flags | output | 3 | Invert, raster-8 and blink cursor flags |
| disp_flags | output | 3 | Character, segment and line-cursor enables |
| pwr_flags | output | 3 | Amplifier, sleep and standby |
| line_cnt | output | 2 | Number of display lines |
| dbl_line | output | 3 | Double-height line select |
| start_line | output | 3 | Display start line |
| contrast | output | 4 | Contrast value |
| start_row | output | 3 | Display start raster row |
| ann_en | output | 1 | Annunciator enable |
| ann_addr | output | 4 | Annunciator/segment RAM address |
| clear_req | output | 1 | One-cycle display-clear request |
| osc_req | output | 1 | One-cycle oscillator-start request |

## Verification
The bench checks the edges of the busy window: the first and last busy cycle of both the short and the long interval. A design with a counter that is off by one would free the bus one cycle early or late. Commands sent in the middle of the window must be dropped. A design that does not gate them would load fields or restart the timer. The split start-line and split address loads are each sent in both halves, so that a clobbered neighbouring bit shows up. Data accesses step the counter across both wrap points, 127→0 and 0→127, to expose a counter that saturates or is too narrow. The bench also covers the codes with no effect (0x00, 0xC4, 0x03) and the one-cycle clear and oscillator pulses.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP,
        CMD_CLEAR,
        CMD_HOME,
        CMD_OSC,
        CMD_ENTRY,
        CMD_CURSOR,
        CMD_DISPLAY,
        CMD_POWER,
        CMD_LINES,
        CMD_CONTRAST,
        CMD_SCROLL,
        CMD_ANN,
        CMD_CGRAM,
        CMD_DDR_HI,
        CMD_DDR_LO
    } cmd_e;

    typedef enum logic [2:0] {
        AC_HOLD,
        AC_ZERO,
        AC_CG,
        AC_HI,
        AC_LO,
        AC_STEP
    } ac_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_EXEC
    } busy_st_e;

    typedef struct packed {
        logic       inc_dir;
        logic       clk_div;
        logic [2:0] cur_flags;
        logic [2:0] disp_flags;
        logic [2:0] pwr_flags;
        logic [1:0] line_cnt;
        logic [2:0] dbl_line;
        logic [2:0] start_line;
        logic [3:0] contrast;
        logic [2:0] start_row;
        logic       ann_en;
        logic [3:0] ann_addr;
    } ctrl_t;

endpackage

// File: rtl/lcd_cmd_classify.sv
module lcd_cmd_classify
    import lcd_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       kind
);

    always_comb begin
        kind = CMD_NOP;
        unique casez (code)
            8'b111?????: kind = CMD_DDR_LO;
            8'b110000??: kind = CMD_DDR_HI;
            8'b101?????: kind = CMD_CGRAM;
            8'b100?????: kind = CMD_ANN;
            8'b011?????: kind = CMD_SCROLL;
            8'b010?????: kind = CMD_CONTRAST;
            8'b001?????: kind = CMD_LINES;
            8'b00011???: kind = CMD_POWER;
            8'b00010???: kind = CMD_DISPLAY;
            8'b00001???: kind = CMD_CURSOR;
            8'b000001??: kind = CMD_ENTRY;
            8'b00000011: kind = CMD_OSC;
            8'b00000010: kind = CMD_HOME;
            8'b00000001: kind = CMD_CLEAR;
            default:     kind = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/lcd_busy_fsm.sv
module lcd_busy_fsm
    import lcd_cmd_pkg::*;
#(
    parameter int CLR_CYCLES = 310,
    parameter int CMD_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_op,
    output logic busy
);

    localparam int MAXC = (CLR_CYCLES > CMD_CYCLES) ? CLR_CYCLES : CMD_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    busy_st_e        state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_EXEC;
                    cnt_d   = long_op ? CW'(CLR_CYCLES - 1) : CW'(CMD_CYCLES - 1);
                end
            end
            ST_EXEC: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb busy = (state_q == ST_EXEC);

    // R11: busy only ever rises because a timed command was accepted
    assert_busy_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3: a long command is followed by busy
    assert_long_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && long_op) |=> busy);

    // R12: the decoder never starts the timer while it is running
    assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/lcd_addr_counter.sv
module lcd_addr_counter
    import lcd_cmd_pkg::*;
#(
    parameter int AW    = 7,
    parameter int LOW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ac_op_e           op,
    input  logic             up,
    input  logic [LOW_W-1:0] load_val,
    output logic [AW-1:0]    ac
);

    localparam int HI_W = AW - LOW_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac <= '0;
        end else begin
            unique case (op)
                AC_HOLD: ac <= ac;
                AC_ZERO: ac <= '0;
                AC_CG:   ac <= {{HI_W{1'b0}}, load_val};
                AC_HI:   ac <= {load_val[HI_W-1:0], ac[LOW_W-1:0]};
                AC_LO:   ac <= {ac[AW-1:LOW_W], load_val};
                AC_STEP: ac <= up ? ac + 1'b1 : ac - 1'b1;
                default: ac <= ac;
            endcase
        end
    end

    // R13: an upward step adds one modulo the counter width
    assert_step_up_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AC_STEP && up) |=> ac == $past(ac) + 1'b1);

    // R13: a downward step subtracts one modulo the counter width
    assert_step_dn_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AC_STEP && !up) |=> ac == $past(ac) - 1'b1);

    // R10: a low-part load keeps the upper bits
    assert_lo_keeps_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AC_LO) |=> ac[AW-1:LOW_W] == $past(ac[AW-1:LOW_W]));

    // R3 / R4: a zeroing command empties the counter
    assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AC_ZERO) |=> ac == '0);

endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
    import lcd_cmd_pkg::*;
#(
    parameter int CLR_CYCLES = 310,
    parameter int CMD_CYCLES = 10,
    parameter int AW         = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          rs,
    input  logic          bus_rd,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          busy,
    output logic [AW-1:0] addr_cnt,
    output logic          inc_dir,
    output logic          clk_div,
    output logic [2:0]    cur_flags,
    output logic [2:0]    disp_flags,
    output logic [2:0]    pwr_flags,
    output logic [1:0]    line_cnt,
    output logic [2:0]    dbl_line,
    output logic [2:0]    start_line,
    output logic [3:0]    contrast,
    output logic [2:0]    start_row,
    output logic          ann_en,
    output logic [3:0]    ann_addr,
    output logic          clear_req,
    output logic          osc_req
);

    localparam int LOW_W = 5;

    cmd_e   kind;
    ac_op_e ac_op;
    ctrl_t  ctrl_q;
    logic   cmd_wr, accept, data_acc, timed, long_op;

    lcd_cmd_classify u_classify (
        .code (wdata),
        .kind (kind)
    );

    always_comb begin
        cmd_wr   = bus_en && !rs && !bus_rd;
        accept   = cmd_wr && !busy;
        data_acc = bus_en && rs;
        timed    = accept && (kind != CMD_NOP) && (kind != CMD_OSC);
        long_op  = (kind == CMD_CLEAR);
    end

    lcd_busy_fsm #(
        .CLR_CYCLES (CLR_CYCLES),
        .CMD_CYCLES (CMD_CYCLES)
    ) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (timed),
        .long_op (long_op),
        .busy    (busy)
    );

    always_comb begin
        ac_op = AC_HOLD;
        if (data_acc) begin
            ac_op = AC_STEP;
        end else if (accept) begin
            unique case (kind)
                CMD_CLEAR, CMD_HOME: ac_op = AC_ZERO;
                CMD_CGRAM:           ac_op = AC_CG;
                CMD_DDR_HI:          ac_op = AC_HI;
                CMD_DDR_LO:          ac_op = AC_LO;
                default:             ac_op = AC_HOLD;
            endcase
        end
    end

    lcd_addr_counter #(
        .AW    (AW),
        .LOW_W (LOW_W)
    ) u_ac (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (ac_op),
        .up       (ctrl_q.inc_dir),
        .load_val (wdata[LOW_W-1:0]),
        .ac       (addr_cnt)
    );

    // control register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            clear_req <= 1'b0;
            osc_req   <= 1'b0;
        end else begin
            clear_req <= accept && (kind == CMD_CLEAR);
            osc_req   <= accept && (kind == CMD_OSC);
            if (accept) begin
                unique case (kind)
                    CMD_ENTRY: begin
                        ctrl_q.inc_dir <= wdata[1];
                        ctrl_q.clk_div <= wdata[0];
                    end
                    CMD_CURSOR:  ctrl_q.cur_flags  <= wdata[2:0];
                    CMD_DISPLAY: ctrl_q.disp_flags <= wdata[2:0];
                    CMD_POWER:   ctrl_q.pwr_flags  <= wdata[2:0];
                    CMD_LINES: begin
                        ctrl_q.line_cnt <= wdata[4:3];
                        ctrl_q.dbl_line <= wdata[2:0];
                    end
                    CMD_CONTRAST: begin
                        ctrl_q.start_line[2] <= wdata[4];
                        ctrl_q.contrast      <= wdata[3:0];
                    end
                    CMD_SCROLL: begin
                        ctrl_q.start_line[1:0] <= wdata[4:3];
                        ctrl_q.start_row       <= wdata[2:0];
                    end
                    CMD_ANN: begin
                        ctrl_q.ann_en   <= wdata[4];
                        ctrl_q.ann_addr <= wdata[3:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        inc_dir    = ctrl_q.inc_dir;
        clk_div    = ctrl_q.clk_div;
        cur_flags  = ctrl_q.cur_flags;
        disp_flags = ctrl_q.disp_flags;
        pwr_flags  = ctrl_q.pwr_flags;
        line_cnt   = ctrl_q.line_cnt;
        dbl_line   = ctrl_q.dbl_line;
        start_line = ctrl_q.start_line;
        contrast   = ctrl_q.contrast;
        start_row  = ctrl_q.start_row;
        ann_en     = ctrl_q.ann_en;
        ann_addr   = ctrl_q.ann_addr;
        rdata      = rs ? 8'h00 : {busy, addr_cnt};
    end

    // R12: a command while busy leaves every control field untouched
    assert_busy_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(ctrl_q));

    // R5: oscillator start never makes the block busy
    assert_osc_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == CMD_OSC) |=> !busy);

    // R3: the clear pulse lasts exactly one cycle
    assert_clear_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> !clear_req);

    // R13: a data access never starts the busy timer
    assert_data_no_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !busy) |=> !busy);

endmodule

// File: tb/tb_lcd_cmd_decoder.sv
module tb_lcd_cmd_decoder;

    localparam int CLR_N = 310;
    localparam int CMD_N = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, rs = 1'b0, bus_rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       busy, inc_dir, clk_div, ann_en, clear_req, osc_req;
    logic [6:0] addr_cnt;
    logic [2:0] cur_flags, disp_flags, pwr_flags, dbl_line, start_line, start_row;
    logic [1:0] line_cnt;
    logic [3:0] contrast, ann_addr;

    int n_chk = 0;
    int n_fail = 0;
    string phase = "R1 reset";

    always #5 clk = ~clk;

    lcd_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .rs(rs), .bus_rd(bus_rd),
        .wdata(wdata), .rdata(rdata), .busy(busy), .addr_cnt(addr_cnt),
        .inc_dir(inc_dir), .clk_div(clk_div), .cur_flags(cur_flags),
        .disp_flags(disp_flags), .pwr_flags(pwr_flags), .line_cnt(line_cnt),
        .dbl_line(dbl_line), .start_line(start_line), .contrast(contrast),
        .start_row(start_row), .ann_en(ann_en), .ann_addr(ann_addr),
        .clear_req(clear_req), .osc_req(osc_req)
    );

    // behavioural reference state
    int m_ac, m_left, m_inc, m_div, m_cur, m_disp, m_pwr, m_lines, m_dbl;
    int m_sl, m_con, m_row, m_aen, m_aad, m_clr, m_osc;

    task automatic m_reset();
        m_ac = 0; m_left = 0; m_inc = 0; m_div = 0; m_cur = 0; m_disp = 0;
        m_pwr = 0; m_lines = 0; m_dbl = 0; m_sl = 0; m_con = 0; m_row = 0;
        m_aen = 0; m_aad = 0; m_clr = 0; m_osc = 0;
    endtask

    initial m_reset();

    always @(posedge clk) begin
        int v;
        int timed;
        int was_busy;
        if (!rst_n) begin
            m_reset();
        end else begin
            was_busy = (m_left > 0);
            timed = 0;
            m_clr = 0;
            m_osc = 0;
            if (m_left > 0) m_left = m_left - 1;
            if (bus_en && rs) begin
                m_ac = (m_ac + (m_inc ? 1 : 127)) % 128;
            end else if (bus_en && !bus_rd && !was_busy) begin
                v = int'(wdata);
                if (v >= 224)      begin m_ac = (m_ac / 32) * 32 + v % 32; timed = CMD_N; end
                else if (v >= 192) begin
                    if (v < 196) begin m_ac = (v % 4) * 32 + m_ac % 32; timed = CMD_N; end
                end
                else if (v >= 160) begin m_ac = v % 32; timed = CMD_N; end
                else if (v >= 128) begin m_aen = (v / 16) % 2; m_aad = v % 16; timed = CMD_N; end
                else if (v >= 96)  begin m_sl = (m_sl / 4) * 4 + (v / 8) % 4; m_row = v % 8; timed = CMD_N; end
                else if (v >= 64)  begin m_sl = ((v / 16) % 2) * 4 + m_sl % 4; m_con = v % 16; timed = CMD_N; end
                else if (v >= 32)  begin m_lines = (v / 8) % 4; m_dbl = v % 8; timed = CMD_N; end
                else if (v >= 24)  begin m_pwr = v % 8; timed = CMD_N; end
                else if (v >= 16)  begin m_disp = v % 8; timed = CMD_N; end
                else if (v >= 8)   begin m_cur = v % 8; timed = CMD_N; end
                else if (v >= 4)   begin m_inc = (v / 2) % 2; m_div = v % 2; timed = CMD_N; end
                else if (v == 3)   m_osc = 1;
                else if (v == 2)   begin m_ac = 0; timed = CMD_N; end
                else if (v == 1)   begin m_ac = 0; m_clr = 1; timed = CLR_N; end
                if (timed > 0) m_left = timed;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL [%s] %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
        end
    endtask

    // compare every clock, 3 ns after the edge
    always @(posedge clk) begin
        #3;
        chk("R11 busy", int'(busy), (m_left > 0) ? 1 : 0);
        chk("R13 addr_cnt", int'(addr_cnt), m_ac);
        chk("R2 rdata", int'(rdata), rs ? 0 : ((m_left > 0) ? 128 : 0) + m_ac);
        chk("R6 inc_dir", int'(inc_dir), m_inc);
        chk("R6 clk_div", int'(clk_div), m_div);
        chk("R6 cur_flags", int'(cur_flags), m_cur);
        chk("R6 disp_flags", int'(disp_flags), m_disp);
        chk("R6 pwr_flags", int'(pwr_flags), m_pwr);
        chk("R7 line_cnt", int'(line_cnt), m_lines);
        chk("R7 dbl_line", int'(dbl_line), m_dbl);
        chk("R7 start_line", int'(start_line), m_sl);
        chk("R7 contrast", int'(contrast), m_con);
        chk("R7 start_row", int'(start_row), m_row);
        chk("R8 ann_en", int'(ann_en), m_aen);
        chk("R8 ann_addr", int'(ann_addr), m_aad);
        chk("R3 clear_req", int'(clear_req), m_clr);
        chk("R5 osc_req", int'(osc_req), m_osc);
    end

    task automatic access(input logic r_s, input logic rd, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; rs = r_s; bus_rd = rd; wdata = d;
        @(negedge clk);
        bus_en = 1'b0; rs = 1'b0; bus_rd = 1'b0; wdata = 8'h00;
    endtask

    task automatic cmd(input logic [7:0] d);
        access(1'b0, 1'b0, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL [watchdog] run did not complete");
        finish_run();
    end

    initial begin
        idle(3);
        phase = "R1 reset";
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 addr in reset", int'(addr_cnt), 0);
        rst_n = 1'b1;
        idle(2);
        phase = "R2 status read";
        access(1'b0, 1'b1, 8'hFF);
        phase = "R6 entry up";
        cmd(8'h06); idle(CMD_N);
        phase = "R13 step up";
        repeat (3) access(1'b1, 1'b0, 8'h55);
        access(1'b1, 1'b1, 8'h00);
        phase = "R6 flags";
        cmd(8'h0D); idle(CMD_N);
        cmd(8'h17); idle(CMD_N);
        cmd(8'h1A); idle(CMD_N);
        phase = "R7 lines/contrast/scroll";
        cmd(8'h2B); idle(CMD_N);
        cmd(8'h5A); idle(CMD_N);
        cmd(8'h7D); idle(CMD_N);
        cmd(8'h68); idle(CMD_N);
        cmd(8'h45); idle(CMD_N);
        phase = "R8 annunciator";
        cmd(8'h9C); idle(CMD_N);
        phase = "R9 cgram";
        cmd(8'hB5); idle(CMD_N);
        phase = "R10 ddram split";
        cmd(8'hC3); idle(CMD_N);
        cmd(8'hEA); idle(CMD_N);
        cmd(8'hC1); idle(CMD_N);
        phase = "R13 wrap up";
        cmd(8'hFF); idle(CMD_N);
        cmd(8'hC3); idle(CMD_N);
        access(1'b1, 1'b0, 8'h00);
        phase = "R13 wrap down";
        cmd(8'h04); idle(CMD_N);
        access(1'b1, 1'b0, 8'h00);
        access(1'b1, 1'b1, 8'h00);
        phase = "R12 drop while busy";
        cmd(8'h1F);
        cmd(8'h0F);
        cmd(8'h01);
        cmd(8'hA7);
        idle(CMD_N);
        phase = "R13 data while busy";
        cmd(8'h16);
        access(1'b1, 1'b0, 8'h00);
        idle(CMD_N);
        phase = "R5 no-op codes";
        cmd(8'h00); cmd(8'hC4); cmd(8'hDF); cmd(8'h03);
        idle(2);
        phase = "R3 clear";
        cmd(8'hE5); idle(CMD_N);
        cmd(8'h01);
        idle(CLR_N / 2);
        cmd(8'h3F);
        idle(CLR_N);
        phase = "R4 home";
        cmd(8'hE9); idle(CMD_N);
        cmd(8'h02); idle(CMD_N + 2);
        phase = "R1 reset again";
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        finish_run();
    end

endmodule